// File: doc/BRIEF.md
# Tag-based reservation station scheduler

This block schedules instructions dynamically. Decoded instructions arrive in program order and each is placed in a free reservation station of its functional-unit type. For each source operand the station takes either the current register value or, if a station is still going to write that register, the index of that station. The station then records its own index as the pending writer of its destination register. A station whose operands are all present is offered to its unit at once, whatever the state of older stations.

Completions come back on one result bus. The bus carries the index of the completing station and its value. Every station waiting on that index takes the value. The architectural register is written only when its status entry still names the completing station. Completions without a destination register free their station and leave the bus alone. The functional units sit outside the block. Each unit holds its result until the block grants the result bus to it.

Top module: `tag_sched`

## Requirements
- R1: After reset every station is free, no register has a pending writer, register k holds the value k, no issue strobe and no bus broadcast is active, and a dispatch of every unit type is accepted.
- R2: At dispatch, a source register with no pending writer supplies its register value, and a source with a pending writer supplies that writer's index, so the station waits.
- R3: Unit type codes are 0 ALU, 1 load, 2 store, 3 FP. Stations 0, 1 and 2 serve ALU, load and store, and stations 3 and 4 serve FP. A dispatch goes to the lowest free station of its type. When no such station is free, `dispReady` is low and a presented dispatch changes no state.
- R4: `issueValid[i]` is high for exactly one cycle, in the first cycle in which station i holds both operand values, even when older stations are still waiting.
- R5: A broadcast on the result bus supplies its value to every waiting source that holds the broadcast index. Such a station then issues with that value.
- R6: At writeback, the destination register is written and its pending mark cleared only if its status entry still names the completing station. A completion from an older writer leaves the register value and its pending mark unchanged.
- R7: A dispatch to a register that already has a pending writer is accepted without stall. The register's status entry then names the new station.
- R8: A completion from a station with no destination register is granted in the same cycle and frees the station. It makes no broadcast.
- R9: At most one broadcast happens per cycle. Among completing stations with a destination, the lowest index is granted. The others get no grant and keep requesting.
- R10: When a dispatch reads a source whose pending writer broadcasts in that same cycle, the new station takes the broadcast value and does not wait.
- R11: `dispTag` is the index of the station that a dispatch would take, and `cdbTag` is the index of the broadcasting station.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dispValid | input | 1 | Dispatch request |
| dispFu | input | 2 | Unit type code of the instruction |
| dispOp | input | OP_W | Opcode, passed to the unit at issue |
| dispHasDst | input | 1 | Instruction writes a register |
| dispDst | input | log2(NUM_REGS) | Destination register |
| dispSrc1 | input | log2(NUM_REGS) | First source register |
| dispSrc2 | input | log2(NUM_REGS) | Second source register |
| dispReady | output | 1 | A free station of type dispFu exists |
| dispTag | output | 3 | Station index that the dispatch takes |
| issueValid | output | 5 | Per-station issue strobe |
| issueOp | output | 5*OP_W | Per-station opcode |
| issueA | output | 5*DATA_W | Per-station first operand |
| issueB | output | 5*DATA_W | Per-station second operand |
| doneValid | input | 5 | Per-station completion request from its unit |
| doneValue | input | 5*DATA_W | Per-station result |
| doneGrant | output | 5 | Completion accepted and station freed |
| cdbValid | output | 1 | Result bus broadcast |
| cdbTag | output | 3 | Index of the broadcasting station |
| cdbValue | output | DATA_W | Broadcast value |
| rdAddr | input | log2(NUM_REGS) | Register observation address |
| rdData | output | DATA_W | Architectural value of rdAddr |
| rdPending | output | 1 | rdAddr has a pending writer |

## Verification
The bench uses the default build: 16-bit data, eight registers, 4-bit opcodes and the five-station mix. Because the load and store types each have one station, a second request of the same type produces a structural stall straight away. The two FP stations allow two writers of one register to be in flight at once, and three completions to collide in one cycle. Each station's completion is driven by hand, so the bench controls the completion order. This makes it possible to have an older writer complete late and to have a broadcast coincide with a dispatch.

// File: rtl/tag_sched_pkg.sv
package tag_sched_pkg;
  localparam int RS_COUNT = 5;
  localparam int TAG_W = $clog2(RS_COUNT);

  typedef enum logic [1:0] {
    FU_ALU   = 2'd0,
    FU_LOAD  = 2'd1,
    FU_STORE = 2'd2,
    FU_FP    = 2'd3
  } fu_e;

  // unit type served by each station index
  function automatic fu_e stationFu(input int idx);
    case (idx)
      0:       return FU_ALU;
      1:       return FU_LOAD;
      2:       return FU_STORE;
      default: return FU_FP;
    endcase
  endfunction

  typedef struct packed {
    logic [RS_COUNT-1:0] alloc;
    logic [TAG_W-1:0]    allocTag;
    logic [RS_COUNT-1:0] issue;
    logic [RS_COUNT-1:0] freeMask;
    logic                bcast;
    logic [TAG_W-1:0]    bcastTag;
  } strobe_t;
endpackage

// File: rtl/tag_sched_ctrl.sv
module tag_sched_ctrl
  import tag_sched_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                dispValid,
  input  logic [1:0]          dispFu,
  input  logic [RS_COUNT-1:0] opsReady,
  input  logic [RS_COUNT-1:0] hasDst,
  input  logic [RS_COUNT-1:0] doneValid,
  output strobe_t             strobe,
  output logic                dispReady,
  output logic [RS_COUNT-1:0] doneGrant
);
  logic [RS_COUNT-1:0] busy, issued;
  logic [RS_COUNT-1:0] freeMatch, doneLive, dstDone, storeDone, bcastMask, allocMask;
  logic                found, bfound;
  logic [TAG_W-1:0]    pickTag, winTag;

  // free stations of the requested type, lowest index first
  always_comb begin
    found   = 1'b0;
    pickTag = '0;
    allocMask = '0;
    for (int i = 0; i < RS_COUNT; i++) begin
      freeMatch[i] = !busy[i] && (stationFu(i) == fu_e'(dispFu));
      if (freeMatch[i] && !found) begin
        found        = 1'b1;
        pickTag      = TAG_W'(i);
        allocMask[i] = 1'b1;
      end
    end
  end

  assign dispReady = found;

  // completion arbitration: stores bypass the bus, writers share it
  always_comb begin
    doneLive  = doneValid & busy & issued;
    dstDone   = doneLive & hasDst;
    storeDone = doneLive & ~hasDst;
    bfound    = 1'b0;
    winTag    = '0;
    bcastMask = '0;
    for (int i = 0; i < RS_COUNT; i++) begin
      if (dstDone[i] && !bfound) begin
        bfound       = 1'b1;
        winTag       = TAG_W'(i);
        bcastMask[i] = 1'b1;
      end
    end
  end

  always_comb begin
    strobe.alloc    = (dispValid && found) ? allocMask : '0;
    strobe.allocTag = pickTag;
    strobe.issue    = busy & ~issued & opsReady;
    strobe.freeMask = storeDone | bcastMask;
    strobe.bcast    = bfound;
    strobe.bcastTag = winTag;
  end

  assign doneGrant = strobe.freeMask;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= '0;
      issued <= '0;
    end else begin
      busy   <= (busy | strobe.alloc) & ~strobe.freeMask;
      issued <= (issued | strobe.issue) & ~strobe.freeMask & ~strobe.alloc;
    end
  end

  // R3
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dispValid && !dispReady) |-> (strobe.alloc == '0));

  // R8
  no_dst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.bcast |-> hasDst[strobe.bcastTag]);

  // R9
  one_bus_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(doneGrant & hasDst) <= 1);

  generate
    for (genvar g = 0; g < RS_COUNT; g++) begin : gIssueChk
      // R4
      issue_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe.issue[g] |=> !strobe.issue[g]);
    end
  endgenerate
endmodule

// File: rtl/tag_sched_dp.sv
module tag_sched_dp
  import tag_sched_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int NUM_REGS = 8,
  parameter int OP_W     = 4,
  localparam int REG_W   = $clog2(NUM_REGS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  strobe_t                    strobe,
  input  logic [OP_W-1:0]            dispOp,
  input  logic                       dispHasDst,
  input  logic [REG_W-1:0]           dispDst,
  input  logic [REG_W-1:0]           dispSrc1,
  input  logic [REG_W-1:0]           dispSrc2,
  input  logic [RS_COUNT*DATA_W-1:0] doneValue,
  input  logic [REG_W-1:0]           rdAddr,
  output logic [RS_COUNT-1:0]        opsReady,
  output logic [RS_COUNT-1:0]        hasDstVec,
  output logic [RS_COUNT*OP_W-1:0]   issueOp,
  output logic [RS_COUNT*DATA_W-1:0] issueA,
  output logic [RS_COUNT*DATA_W-1:0] issueB,
  output logic [DATA_W-1:0]          cdbValue,
  output logic [DATA_W-1:0]          rdData,
  output logic                       rdPending
);
  // station fields
  logic [OP_W-1:0]   rsOp   [RS_COUNT];
  logic [REG_W-1:0]  rsDst  [RS_COUNT];
  logic [TAG_W-1:0]  rsTag1 [RS_COUNT];
  logic [TAG_W-1:0]  rsTag2 [RS_COUNT];
  logic [DATA_W-1:0] rsVal1 [RS_COUNT];
  logic [DATA_W-1:0] rsVal2 [RS_COUNT];
  logic [RS_COUNT-1:0] rsHasDst, rsPend1, rsPend2;

  // architectural state and producer status
  logic [DATA_W-1:0] regFile [NUM_REGS];
  logic [TAG_W-1:0]  statTag [NUM_REGS];
  logic [NUM_REGS-1:0] statPend;

  logic              accept;
  logic [REG_W-1:0]  wbReg;
  logic              wbHit;
  logic [REG_W-1:0]  srcIdx  [2];
  logic              srcPend [2];
  logic [TAG_W-1:0]  srcTag  [2];
  logic [DATA_W-1:0] srcVal  [2];

  assign accept   = |strobe.alloc;
  assign cdbValue = doneValue[strobe.bcastTag*DATA_W +: DATA_W];
  assign wbReg    = rsDst[strobe.bcastTag];
  assign wbHit    = strobe.bcast && statPend[wbReg] && (statTag[wbReg] == strobe.bcastTag);

  // operand read at dispatch, with same-cycle bus capture
  assign srcIdx[0] = dispSrc1;
  assign srcIdx[1] = dispSrc2;
  always_comb begin
    for (int k = 0; k < 2; k++) begin
      srcTag[k] = statTag[srcIdx[k]];
      if (!statPend[srcIdx[k]]) begin
        srcPend[k] = 1'b0;
        srcVal[k]  = regFile[srcIdx[k]];
      end else if (strobe.bcast && srcTag[k] == strobe.bcastTag) begin
        srcPend[k] = 1'b0;
        srcVal[k]  = cdbValue;
      end else begin
        srcPend[k] = 1'b1;
        srcVal[k]  = '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsHasDst <= '0;
      rsPend1  <= '0;
      rsPend2  <= '0;
      for (int i = 0; i < RS_COUNT; i++) begin
        rsOp[i]   <= '0;
        rsDst[i]  <= '0;
        rsTag1[i] <= '0;
        rsTag2[i] <= '0;
        rsVal1[i] <= '0;
        rsVal2[i] <= '0;
      end
    end else begin
      for (int i = 0; i < RS_COUNT; i++) begin
        if (strobe.alloc[i]) begin
          rsOp[i]     <= dispOp;
          rsDst[i]    <= dispDst;
          rsHasDst[i] <= dispHasDst;
          rsPend1[i]  <= srcPend[0];
          rsTag1[i]   <= srcTag[0];
          rsVal1[i]   <= srcVal[0];
          rsPend2[i]  <= srcPend[1];
          rsTag2[i]   <= srcTag[1];
          rsVal2[i]   <= srcVal[1];
        end else begin
          if (rsPend1[i] && strobe.bcast && rsTag1[i] == strobe.bcastTag) begin
            rsPend1[i] <= 1'b0;
            rsVal1[i]  <= cdbValue;
          end
          if (rsPend2[i] && strobe.bcast && rsTag2[i] == strobe.bcastTag) begin
            rsPend2[i] <= 1'b0;
            rsVal2[i]  <= cdbValue;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      statPend <= '0;
      for (int r = 0; r < NUM_REGS; r++) begin
        regFile[r] <= DATA_W'(r);
        statTag[r] <= '0;
      end
    end else begin
      for (int r = 0; r < NUM_REGS; r++) begin
        if (wbHit && wbReg == REG_W'(r)) begin
          regFile[r]  <= cdbValue;
          statPend[r] <= 1'b0;
        end
        if (accept && dispHasDst && dispDst == REG_W'(r)) begin
          statPend[r] <= 1'b1;
          statTag[r]  <= strobe.allocTag;
        end
      end
    end
  end

  generate
    for (genvar g = 0; g < RS_COUNT; g++) begin : gOut
      assign opsReady[g]                   = !rsPend1[g] && !rsPend2[g];
      assign hasDstVec[g]                  = rsHasDst[g];
      assign issueOp[g*OP_W +: OP_W]       = rsOp[g];
      assign issueA[g*DATA_W +: DATA_W]    = rsVal1[g];
      assign issueB[g*DATA_W +: DATA_W]    = rsVal2[g];

      // R5
      wake_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsPend1[g] && strobe.bcast && rsTag1[g] == strobe.bcastTag && !strobe.alloc[g])
        |=> (!rsPend1[g] && rsVal1[g] == $past(cdbValue)));
    end
  endgenerate

  assign rdData    = regFile[rdAddr];
  assign rdPending = statPend[rdAddr];

  generate
    for (genvar g = 0; g < NUM_REGS; g++) begin : gRegChk
      // R7
      claim_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && dispHasDst && dispDst == REG_W'(g))
        |=> (statPend[g] && statTag[g] == $past(strobe.allocTag)));
      // R6
      stale_writer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe.bcast && rsDst[strobe.bcastTag] == REG_W'(g) &&
         statTag[g] != strobe.bcastTag && !(accept && dispHasDst && dispDst == REG_W'(g)))
        |=> (regFile[g] == $past(regFile[g]) && statPend[g] == $past(statPend[g])));
    end
  endgenerate
endmodule

// File: rtl/tag_sched.sv
module tag_sched
  import tag_sched_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int NUM_REGS = 8,
  parameter int OP_W     = 4,
  localparam int REG_W   = $clog2(NUM_REGS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       dispValid,
  input  logic [1:0]                 dispFu,
  input  logic [OP_W-1:0]            dispOp,
  input  logic                       dispHasDst,
  input  logic [REG_W-1:0]           dispDst,
  input  logic [REG_W-1:0]           dispSrc1,
  input  logic [REG_W-1:0]           dispSrc2,
  output logic                       dispReady,
  output logic [TAG_W-1:0]           dispTag,
  output logic [RS_COUNT-1:0]        issueValid,
  output logic [RS_COUNT*OP_W-1:0]   issueOp,
  output logic [RS_COUNT*DATA_W-1:0] issueA,
  output logic [RS_COUNT*DATA_W-1:0] issueB,
  input  logic [RS_COUNT-1:0]        doneValid,
  input  logic [RS_COUNT*DATA_W-1:0] doneValue,
  output logic [RS_COUNT-1:0]        doneGrant,
  output logic                       cdbValid,
  output logic [TAG_W-1:0]           cdbTag,
  output logic [DATA_W-1:0]          cdbValue,
  input  logic [REG_W-1:0]           rdAddr,
  output logic [DATA_W-1:0]          rdData,
  output logic                       rdPending
);
  strobe_t             strobe;
  logic [RS_COUNT-1:0] opsReady, hasDstVec;

  tag_sched_ctrl uCtrl (
    .clk, .rst_n, .dispValid, .dispFu,
    .opsReady, .hasDst(hasDstVec), .doneValid,
    .strobe, .dispReady, .doneGrant
  );

  tag_sched_dp #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .OP_W(OP_W)) uDp (
    .clk, .rst_n, .strobe, .dispOp, .dispHasDst, .dispDst, .dispSrc1, .dispSrc2,
    .doneValue, .rdAddr, .opsReady, .hasDstVec, .issueOp, .issueA, .issueB,
    .cdbValue, .rdData, .rdPending
  );

  assign dispTag    = strobe.allocTag;
  assign issueValid = strobe.issue;
  assign cdbValid   = strobe.bcast;
  assign cdbTag     = strobe.bcastTag;
endmodule

// File: tb/tag_sched_test.sv
module tag_sched_test;
  localparam int N = 5;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dispValid = 1'b0;
  logic [1:0] dispFu = 2'd0;
  logic [3:0] dispOp = 4'd0;
  logic dispHasDst = 1'b0;
  logic [2:0] dispDst = 3'd0, dispSrc1 = 3'd0, dispSrc2 = 3'd0;
  logic dispReady;
  logic [2:0] dispTag;
  logic [N-1:0] issueValid;
  logic [N*4-1:0] issueOp;
  logic [N*DW-1:0] issueA, issueB;
  logic [N-1:0] doneValid = '0;
  logic [N*DW-1:0] doneValue = '0;
  logic [N-1:0] doneGrant;
  logic cdbValid;
  logic [2:0] cdbTag;
  logic [DW-1:0] cdbValue;
  logic [2:0] rdAddr = 3'd0;
  logic [DW-1:0] rdData;
  logic rdPending;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  tag_sched uut (.*);

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic doDispatch(input int fu, input bit hasD, input int dst, input int s1, input int s2, input int expTag);
    @(negedge clk);
    dispValid = 1; dispFu = 2'(fu); dispOp = 4'(fu + 1); dispHasDst = hasD;
    dispDst = 3'(dst); dispSrc1 = 3'(s1); dispSrc2 = 3'(s2);
    #1;
    chk(dispReady == 1'b1, "R3", "dispReady", dispReady, 1);
    chk(dispTag == 3'(expTag), "R11", "dispTag", dispTag, expTag);
    @(posedge clk); #1;
    dispValid = 0;
  endtask

  task automatic checkIssue(input int idx, input int a, input int b, input string req);
    @(negedge clk); #1;
    chk(issueValid[idx] == 1'b1, "R4", "issueValid", issueValid[idx], 1);
    chk(issueA[idx*DW +: DW] == 16'(a), req, "issueA", issueA[idx*DW +: DW], a);
    chk(issueB[idx*DW +: DW] == 16'(b), req, "issueB", issueB[idx*DW +: DW], b);
    @(negedge clk); #1;
    chk(issueValid[idx] == 1'b0, "R4", "issue pulse ended", issueValid[idx], 0);
  endtask

  task automatic complete(input int idx, input int val, input bit expBus);
    @(negedge clk);
    doneValid[idx] = 1'b1;
    doneValue[idx*DW +: DW] = 16'(val);
    #1;
    chk(doneGrant == 5'(1 << idx), expBus ? "R9" : "R8", "doneGrant", doneGrant, 1 << idx);
    chk(cdbValid == expBus, expBus ? "R11" : "R8", "cdbValid", cdbValid, expBus);
    if (expBus) begin
      chk(cdbTag == 3'(idx), "R11", "cdbTag", cdbTag, idx);
      chk(cdbValue == 16'(val), "R5", "cdbValue", cdbValue, val);
    end
    @(posedge clk); #1;
    doneValid[idx] = 1'b0;
  endtask

  task automatic checkReg(input int r, input int val, input bit pend, input string req);
    rdAddr = 3'(r);
    #1;
    chk(rdData == 16'(val), req, "rdData", rdData, val);
    chk(rdPending == pend, req, "rdPending", rdPending, pend);
  endtask

  task automatic testReset();
    for (int k = 0; k < 8; k++) checkReg(k, k, 0, "R1");
    chk(issueValid == '0, "R1", "issueValid", issueValid, 0);
    chk(cdbValid == 1'b0, "R1", "cdbValid", cdbValid, 0);
    for (int f = 0; f < 4; f++) begin
      dispFu = 2'(f); #1;
      chk(dispReady == 1'b1, "R1", "dispReady per type", dispReady, 1);
    end
  endtask

  task automatic testBasic();
    doDispatch(0, 1, 3, 1, 2, 0);
    checkReg(3, 3, 1, "R7");
    checkIssue(0, 1, 2, "R2");
    complete(0, 103, 1);
    checkReg(3, 103, 0, "R6");
  endtask

  task automatic testDepend();
    doDispatch(1, 1, 4, 1, 0, 1);
    checkIssue(1, 1, 0, "R2");
    doDispatch(3, 1, 5, 4, 2, 3);
    @(negedge clk);
    dispFu = 2'd1; #1;
    chk(dispReady == 1'b0, "R3", "load station taken", dispReady, 0);
    chk(issueValid[3] == 1'b0, "R2", "consumer waits on tag", issueValid[3], 0);
    dispValid = 1; dispHasDst = 1; dispDst = 3'd7;
    @(posedge clk); #1;
    dispValid = 0;
    checkReg(7, 7, 0, "R3");
    doDispatch(3, 1, 6, 1, 2, 4);
    @(negedge clk); #1;
    chk(issueValid[4] == 1'b1, "R4", "younger issues first", issueValid[4], 1);
    chk(issueValid[3] == 1'b0, "R4", "older still waits", issueValid[3], 0);
    complete(1, 55, 1);
    checkIssue(3, 55, 2, "R5");
    complete(3, 57, 1);
    complete(4, 3, 1);
    checkReg(4, 55, 0, "R6");
    checkReg(5, 57, 0, "R6");
    checkReg(6, 3, 0, "R6");
  endtask

  task automatic testOlderWriter();
    doDispatch(0, 1, 7, 1, 2, 0);
    doDispatch(3, 1, 7, 1, 1, 3);
    checkReg(7, 7, 1, "R7");
    checkIssue(3, 1, 1, "R7");
    complete(0, 99, 1);
    checkReg(7, 7, 1, "R6");
    complete(3, 77, 1);
    checkReg(7, 77, 0, "R6");
  endtask

  task automatic testStore();
    doDispatch(2, 0, 0, 3, 4, 2);
    checkIssue(2, 103, 55, "R2");
    complete(2, 0, 0);
    @(negedge clk);
    dispFu = 2'd2; #1;
    chk(dispReady == 1'b1, "R8", "store station freed", dispReady, 1);
  endtask

  task automatic testArbitrate();
    doDispatch(0, 1, 0, 1, 1, 0);
    doDispatch(3, 1, 2, 1, 1, 3);
    doDispatch(3, 1, 1, 1, 1, 4);
    checkIssue(4, 1, 1, "R2");
    @(negedge clk);
    doneValid = 5'b11001;
    doneValue[0*DW +: DW] = 16'd10;
    doneValue[3*DW +: DW] = 16'd20;
    doneValue[4*DW +: DW] = 16'd30;
    #1;
    chk(doneGrant == 5'b00001, "R9", "first grant", doneGrant, 1);
    chk(cdbTag == 3'd0, "R9", "first bus tag", cdbTag, 0);
    @(posedge clk); #1;
    doneValid[0] = 1'b0;
    @(negedge clk); #1;
    chk(doneGrant == 5'b01000, "R9", "second grant", doneGrant, 8);
    chk(cdbTag == 3'd3 && cdbValue == 16'd20, "R9", "second bus tag", cdbTag, 3);
    @(posedge clk); #1;
    doneValid[3] = 1'b0;
    @(negedge clk); #1;
    chk(doneGrant == 5'b10000, "R9", "third grant", doneGrant, 16);
    chk(cdbTag == 3'd4, "R9", "third bus tag", cdbTag, 4);
    @(posedge clk); #1;
    doneValid[4] = 1'b0;
    checkReg(0, 10, 0, "R9");
    checkReg(2, 20, 0, "R9");
    checkReg(1, 30, 0, "R9");
  endtask

  task automatic testBypass();
    doDispatch(1, 1, 5, 0, 0, 1);
    checkIssue(1, 10, 10, "R2");
    @(negedge clk);
    doneValid[1] = 1'b1;
    doneValue[1*DW +: DW] = 16'd42;
    dispValid = 1; dispFu = 2'd3; dispHasDst = 1; dispDst = 3'd6;
    dispSrc1 = 3'd5; dispSrc2 = 3'd2;
    #1;
    chk(cdbValid == 1'b1 && cdbTag == 3'd1, "R11", "bus tag during dispatch", cdbTag, 1);
    chk(dispTag == 3'd3, "R11", "dispTag", dispTag, 3);
    @(posedge clk); #1;
    doneValid[1] = 1'b0;
    dispValid = 0;
    checkIssue(3, 42, 20, "R10");
    complete(3, 62, 1);
    checkReg(5, 42, 0, "R10");
    checkReg(6, 62, 0, "R10");
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    testReset();
    testBasic();
    testDepend();
    testOlderWriter();
    testStore();
    testArbitrate();
    testBypass();
    repeat (2) @(posedge clk);
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule